// File: doc/BRIEF.md
# Sequential Turn Signal Controller

This block drives the six indicator lamps of a vehicle, three per side. When the driver asks for a turn, the lamps on that side light one at a time from the inside out. First one lamp is lit, then two, then three, then all are dark for one step, and then the sweep repeats. A warning request overrides both turn requests and flashes all six lamps together, on for one step and off for the next.

The block contains its own prescaler. The prescaler divides the fast system clock down to a visible step rate, and the state machine moves only on the cycle the prescaler marks. The lamps depend only on the current state, as in a Moore machine. Registered lamp outputs are the default. A parameter selects a cheaper version where the lamps are decoded directly from the state.

The inputs are level signals that are already synchronous to the clock and already debounced. A change of direction part way through a sweep aborts that sweep. The new side's sweep then starts at its first step.

Top module: `turn_lamp_seq`

## Requirements
- R1: A synchronous active-high reset darkens all six lamps at the clock edge where it is sampled. It also clears the prescaler, so the first step after release lands on the STEP_DIV-th rising edge with reset low.
- R2: Lamps change only on step edges, which are every STEP_DIV-th rising edge after reset release. Input changes that come and go between two step edges have no effect on the lamps.
- R3: With only the left request high, each step moves the left lamps through 3'b001, 3'b011, 3'b111, 3'b000 and then repeats. Bit 0 is the innermost lamp. The right lamps stay dark.
- R4: With only the right request high, the right lamps follow the same sequence as R3, bit 0 innermost, and the left lamps stay dark.
- R5: With the warning request high, a step lights all six lamps if they were not all lit, and darkens all six if they were. The two patterns alternate for as long as the request stays high.
- R6: The warning request takes priority over left and right. The left and right levels have no effect on R5's sequence while warning is high.
- R7: A step that sees the opposite direction while a side is part way through its sweep goes straight to that new side's first step: one inner lamp lit, the other side dark.
- R8: A step with no request high darkens all lamps.
- R9: A step with both left and right high and warning low darkens all lamps.
- R10: Lamps on both sides are never lit together, except when all six are lit by the warning flash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| left_i | input | 1 | Left turn request level |
| right_i | input | 1 | Right turn request level |
| hazard_i | input | 1 | Warning flash request level, dominant |
| lamp_left_o | output | 3 | Left lamps, bit 0 innermost |
| lamp_right_o | output | 3 | Right lamps, bit 0 innermost |

## Verification
The properties assume that the request levels are sampled at the same edge as the step marker. They therefore assume the inputs are synchronous and free of bounce at step edges. They also assume that reset is applied before the first step, because the step-spacing check counts from reset. The stimulus changes inputs one nanosecond after a clock edge and holds them across each step edge. A deliberate pulse of the warning request is placed strictly between two step edges, so that R2 is exercised without breaking those assumptions.

// File: rtl/turn_lamp_pkg.sv
package turn_lamp_pkg;

   localparam int unsigned SIDE_LAMPS = 3;
   localparam int unsigned LVL_W      = $clog2(SIDE_LAMPS + 1);

   typedef logic [LVL_W-1:0] lamp_lvl_t;

   typedef enum logic [2:0] {
      ST_DARK = 3'd0,
      ST_L1   = 3'd1,
      ST_L2   = 3'd2,
      ST_L3   = 3'd3,
      ST_R1   = 3'd4,
      ST_R2   = 3'd5,
      ST_R3   = 3'd6,
      ST_ALL  = 3'd7
   } lamp_state_e;

   typedef enum logic [1:0] {
      REQ_NONE  = 2'd0,
      REQ_LEFT  = 2'd1,
      REQ_RIGHT = 2'd2,
      REQ_WARN  = 2'd3
   } lamp_req_e;

   // number of lamps lit on the left side for a given state
   function automatic lamp_lvl_t left_level(lamp_state_e s);
      case (s)
         ST_L1:   return lamp_lvl_t'(1);
         ST_L2:   return lamp_lvl_t'(2);
         ST_L3:   return lamp_lvl_t'(3);
         ST_ALL:  return lamp_lvl_t'(SIDE_LAMPS);
         default: return '0;
      endcase
   endfunction

   // number of lamps lit on the right side for a given state
   function automatic lamp_lvl_t right_level(lamp_state_e s);
      case (s)
         ST_R1:   return lamp_lvl_t'(1);
         ST_R2:   return lamp_lvl_t'(2);
         ST_R3:   return lamp_lvl_t'(3);
         ST_ALL:  return lamp_lvl_t'(SIDE_LAMPS);
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/turn_lamp_tick.sv
module turn_lamp_tick #(
   parameter int unsigned STEP_DIV = 6_250_000
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic step_o
);

   localparam int unsigned CW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEP_DIV - 1);

   generate
      if (STEP_DIV < 2) begin : g_bad_div
         $error("turn_lamp_tick: STEP_DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign step_o = (cnt_q == LAST);

endmodule

// File: rtl/turn_lamp_req.sv
module turn_lamp_req
   import turn_lamp_pkg::*;
(
   input  logic      left_i,
   input  logic      right_i,
   input  logic      hazard_i,
   output lamp_req_e req_o
);

   always_comb begin
      if (hazard_i) begin
         req_o = REQ_WARN;
      end else if (left_i && !right_i) begin
         req_o = REQ_LEFT;
      end else if (right_i && !left_i) begin
         req_o = REQ_RIGHT;
      end else begin
         // idle or contradictory request: go dark
         req_o = REQ_NONE;
      end
   end

endmodule

// File: rtl/turn_lamp_fsm.sv
module turn_lamp_fsm
   import turn_lamp_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_i,
   input  logic        step_i,
   input  lamp_req_e   req_i,
   output lamp_state_e state_q_o,
   output lamp_state_e state_d_o
);

   lamp_state_e state_q;
   lamp_state_e state_d;

   always_comb begin
      state_d = state_q;
      if (step_i) begin
         case (req_i)
            REQ_WARN: begin
               state_d = (state_q == ST_ALL) ? ST_DARK : ST_ALL;
            end
            REQ_LEFT: begin
               case (state_q)
                  ST_L1:   state_d = ST_L2;
                  ST_L2:   state_d = ST_L3;
                  ST_L3:   state_d = ST_DARK;
                  default: state_d = ST_L1;
               endcase
            end
            REQ_RIGHT: begin
               case (state_q)
                  ST_R1:   state_d = ST_R2;
                  ST_R2:   state_d = ST_R3;
                  ST_R3:   state_d = ST_DARK;
                  default: state_d = ST_R1;
               endcase
            end
            default: state_d = ST_DARK;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= ST_DARK;
      end else begin
         state_q <= state_d;
      end
   end

   assign state_q_o = state_q;
   assign state_d_o = state_d;

endmodule

// File: rtl/turn_lamp_drive.sv
module turn_lamp_drive
   import turn_lamp_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  lamp_state_e           state_q_i,
   input  lamp_state_e           state_d_i,
   output logic [SIDE_LAMPS-1:0] left_o,
   output logic [SIDE_LAMPS-1:0] right_o
);

   lamp_state_e           src_state;
   lamp_lvl_t             lvl_l;
   lamp_lvl_t             lvl_r;
   logic [SIDE_LAMPS-1:0] bar_l;
   logic [SIDE_LAMPS-1:0] bar_r;

   // registered variant decodes the next state so lamps move with the state
   assign src_state = REG_OUT ? state_d_i : state_q_i;
   assign lvl_l     = left_level(src_state);
   assign lvl_r     = right_level(src_state);

   generate
      for (genvar i = 0; i < SIDE_LAMPS; i++) begin : g_lamp
         assign bar_l[i] = (lvl_l > lamp_lvl_t'(i));
         assign bar_r[i] = (lvl_r > lamp_lvl_t'(i));
      end

      if (REG_OUT) begin : g_reg
         logic [SIDE_LAMPS-1:0] left_q;
         logic [SIDE_LAMPS-1:0] right_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               left_q  <= '0;
               right_q <= '0;
            end else begin
               left_q  <= bar_l;
               right_q <= bar_r;
            end
         end
         assign left_o  = left_q;
         assign right_o = right_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk_i ^ rst_i ^ (^state_d_i);
         assign left_o  = bar_l;
         assign right_o = bar_r;
      end
   endgenerate

endmodule

// File: rtl/turn_lamp_seq.sv
module turn_lamp_seq
   import turn_lamp_pkg::*;
#(
   parameter int unsigned STEP_DIV = 6_250_000,
   parameter bit          REG_OUT  = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic                  left_i,
   input  logic                  right_i,
   input  logic                  hazard_i,
   output logic [SIDE_LAMPS-1:0] lamp_left_o,
   output logic [SIDE_LAMPS-1:0] lamp_right_o
);

   logic        step_w;
   lamp_req_e   req_w;
   lamp_state_e state_q_w;
   lamp_state_e state_d_w;

   turn_lamp_tick #(
      .STEP_DIV (STEP_DIV)
   ) u_tick (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .step_o (step_w)
   );

   turn_lamp_req u_req (
      .left_i   (left_i),
      .right_i  (right_i),
      .hazard_i (hazard_i),
      .req_o    (req_w)
   );

   turn_lamp_fsm u_fsm (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .step_i    (step_w),
      .req_i     (req_w),
      .state_q_o (state_q_w),
      .state_d_o (state_d_w)
   );

   turn_lamp_drive #(
      .REG_OUT (REG_OUT)
   ) u_drive (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .state_q_i (state_q_w),
      .state_d_i (state_d_w),
      .left_o    (lamp_left_o),
      .right_o   (lamp_right_o)
   );

endmodule

// File: rtl/turn_lamp_seq_chk.sv
module turn_lamp_seq_chk
   import turn_lamp_pkg::*;
#(
   parameter int unsigned STEP_DIV = 6_250_000
) (
   input logic                  clk_i,
   input logic                  rst_i,
   input logic                  left_i,
   input logic                  right_i,
   input logic                  hazard_i,
   input logic                  step_i,
   input logic [SIDE_LAMPS-1:0] lamp_left_i,
   input logic [SIDE_LAMPS-1:0] lamp_right_i
);

   localparam int unsigned GW = $clog2(STEP_DIV) + 1;
   localparam logic [SIDE_LAMPS-1:0] FULL = '1;

   logic [GW-1:0] gap_q;
   logic          all_on;
   logic          all_off;
   logic          go_l;
   logic          go_r;

   always_ff @(posedge clk_i) begin
      if (rst_i)       gap_q <= '0;
      else if (step_i) gap_q <= '0;
      else             gap_q <= gap_q + 1'b1;
   end

   assign all_on  = (lamp_left_i == FULL) && (lamp_right_i == FULL);
   assign all_off = (lamp_left_i == '0) && (lamp_right_i == '0);
   assign go_l    = left_i && !right_i && !hazard_i;
   assign go_r    = right_i && !left_i && !hazard_i;

   // R1
   reset_dark_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> all_off);

   // R2
   step_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      step_i |-> gap_q == GW'(STEP_DIV - 1));

   // R2
   hold_between_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !step_i |=> $stable(lamp_left_i) && $stable(lamp_right_i));

   // R3
   left_grow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      step_i && go_l && lamp_left_i == 3'b001 |=> lamp_left_i == 3'b011 && lamp_right_i == '0);

   // R3
   left_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      step_i && go_l && lamp_left_i == 3'b111 && lamp_right_i == '0 |=> all_off);

   // R4
   right_grow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      step_i && go_r && lamp_right_i == 3'b011 |=> lamp_right_i == 3'b111 && lamp_left_i == '0);

   // R5 R6
   warn_on_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      step_i && hazard_i && !all_on |=> all_on);

   // R5 R6
   warn_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      step_i && hazard_i && all_on |=> all_off);

   // R7
   swap_to_left_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      step_i && go_l && (|lamp_right_i) && !all_on |=> lamp_left_i == 3'b001 && lamp_right_i == '0);

   // R7
   swap_to_right_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      step_i && go_r && (|lamp_left_i) && !all_on |=> lamp_right_i == 3'b001 && lamp_left_i == '0);

   // R8 R9
   dark_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      step_i && !hazard_i && (left_i == right_i) |=> all_off);

   // R10
   one_side_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (|lamp_left_i) && (|lamp_right_i) |-> all_on);

endmodule

bind turn_lamp_seq turn_lamp_seq_chk #(
   .STEP_DIV (STEP_DIV)
) u_chk (
   .clk_i        (clk_i),
   .rst_i        (rst_i),
   .left_i       (left_i),
   .right_i      (right_i),
   .hazard_i     (hazard_i),
   .step_i       (step_w),
   .lamp_left_i  (lamp_left_o),
   .lamp_right_i (lamp_right_o)
);

// File: tb/turn_lamp_seq_bench.sv
`timescale 1ns/1ps
module turn_lamp_seq_bench;

   localparam int DIV = 4;

   typedef struct {
      logic [5:0] exp;
      string      tag;
   } exp_item_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       left_r = 1'b0;
   logic       right_r = 1'b0;
   logic       haz_r = 1'b0;
   logic [2:0] lamp_l;
   logic [2:0] lamp_r;

   int         n_run = 0;
   int         n_fail = 0;
   int         edge_n = 0;
   int         steps_seen = 0;
   logic [5:0] last_seen = '0;
   exp_item_t  q[$];
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   turn_lamp_seq #(
      .STEP_DIV (DIV),
      .REG_OUT  (1'b1)
   ) u_turn_lamp_seq (
      .clk_i        (clk),
      .rst_i        (rst),
      .left_i       (left_r),
      .right_i      (right_r),
      .hazard_i     (haz_r),
      .lamp_left_o  (lamp_l),
      .lamp_right_o (lamp_r)
   );

   task automatic check(input logic [5:0] act, input logic [5:0] exp, input string tag);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: lamps {L,R} actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor: compares at step edges, checks hold elsewhere
   always @(posedge clk) begin
      if (rst) begin
         edge_n = 0;
         #1;
         check({lamp_l, lamp_r}, 6'b000_000, "R1 reset dark");
      end else begin
         edge_n++;
         #1;
         if (edge_n % DIV == 0) begin
            if (q.size() > 0) begin
               exp_item_t it;
               it = q.pop_front();
               check({lamp_l, lamp_r}, it.exp, it.tag);
            end
            steps_seen++;
         end else begin
            check({lamp_l, lamp_r}, last_seen, "R2 hold between steps");
         end
      end
      last_seen = {lamp_l, lamp_r};
   end

   task automatic step(input logic l, input logic r, input logic h,
                       input logic [2:0] el, input logic [2:0] er, input string tag);
      int tgt;
      left_r  = l;
      right_r = r;
      haz_r   = h;
      q.push_back('{exp: {el, er}, tag: tag});
      tgt = steps_seen + 1;
      wait (steps_seen == tgt);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;

      step(1, 0, 0, 3'b001, 3'b000, "R3 left first lamp");
      step(1, 0, 0, 3'b011, 3'b000, "R3 left two lamps");
      step(1, 0, 0, 3'b111, 3'b000, "R3 left three lamps");
      step(1, 0, 0, 3'b000, 3'b000, "R3 left dark step");
      step(1, 0, 0, 3'b001, 3'b000, "R3 left repeats");
      step(1, 0, 0, 3'b011, 3'b000, "R3 left mid sweep");
      step(0, 1, 0, 3'b000, 3'b001, "R7 left to right restart");
      step(0, 1, 0, 3'b000, 3'b011, "R4 right grows");
      step(1, 0, 0, 3'b001, 3'b000, "R7 right to left restart");
      step(0, 0, 1, 3'b111, 3'b111, "R5 warning on");
      step(0, 0, 1, 3'b000, 3'b000, "R5 warning off");
      step(1, 0, 1, 3'b111, 3'b111, "R6 warning beats left");
      step(0, 1, 1, 3'b000, 3'b000, "R6 warning beats right");
      step(0, 1, 1, 3'b111, 3'b111, "R6 warning keeps flashing");
      step(0, 0, 0, 3'b000, 3'b000, "R8 no request dark");
      step(0, 0, 0, 3'b000, 3'b000, "R8 stays dark");
      step(1, 0, 0, 3'b001, 3'b000, "R3 left after dark");
      step(1, 1, 0, 3'b000, 3'b000, "R9 both sides dark");
      step(0, 1, 0, 3'b000, 3'b001, "R4 right first lamp");
      step(0, 1, 0, 3'b000, 3'b011, "R4 right two lamps");

      // R2: warning pulse strictly between step edges must not matter
      begin
         int tgt;
         q.push_back('{exp: 6'b000_111, tag: "R2 ignored pulse, R4 right three"});
         tgt = steps_seen + 1;
         @(negedge clk);
         haz_r = 1'b1;
         @(negedge clk);
         haz_r = 1'b0;
         wait (steps_seen == tgt);
      end

      step(0, 1, 0, 3'b000, 3'b000, "R4 right dark step");
      step(0, 1, 0, 3'b000, 3'b001, "R4 right repeats");
      step(0, 0, 1, 3'b111, 3'b111, "R5 warning from sweep");
      step(1, 0, 0, 3'b001, 3'b000, "R3 left after warning");
      step(1, 0, 0, 3'b011, 3'b000, "R3 left before reset");

      // R1: reset mid sweep, then step timing restarts from release
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      step(1, 0, 0, 3'b001, 3'b000, "R1 sweep restarts after reset");
      step(0, 0, 0, 3'b000, 3'b000, "R8 release to dark");

      done = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule